// File: doc/BRIEF.md
# Power State Sequencing Controller

This block steps a chip through its low-power modes. Software asks for a target mode through a request strobe. The controller accepts the request only along permitted paths, and it rejects and flags any request that skips a step. Four modes are run purely by hardware: full speed, slow, doze and sleep. Standby, deep-sleep and backup are variants that software enters from those modes. The controller drives the PLL bypass and power-down lines, the CPU clock-source select, the CPU clock gate, the main power enable, the core supply switch, the SDRAM self-refresh request and the CPU reset.

Wake from sleep needs only a wake pin level or an RTC alarm pulse, and the CPU keeps running state. Wake from deep-sleep or backup runs a separate sequence. The main power enable turns on first. The core switch follows after the first 32 kHz tick. The CPU reset is released only after a fixed number of 32 kHz ticks. That count is longer after backup, about 2 ms, because no context was kept. A new core-voltage code can be written at any time, but it reaches the output only while the chip sits in a powered-down mode. Loss of supply-good or battery-good forces an SDRAM self-refresh request at once.

All inputs are assumed to be synchronous to `clk`. The PLLs and supplies appear only as enables and a lock flag.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: Reset is synchronous and active low. After reset the state is SLOW (code 1) with pll1_bypass=1, cpu_rst_n=1, sdram_sr_req=0, req_reject=0 and core_vsel=VSEL_INIT (default 1).
- R2: state_o uses this encoding: RUN=0, SLOW=1, DOZE=2, STANDBY=3, SLEEP=4, DEEP-SLEEP=5, BACKUP=6, WAKE=7. The legal paths are RUN to SLOW or STANDBY, STANDBY to RUN, SLOW to DOZE, SLEEP, DEEP-SLEEP or BACKUP, and DOZE to SLOW or SLEEP. A request for the current state is a legal no-op. An accepted request (req_valid=1 with the target on req_mode) changes state_o on the next clock edge.
- R3: Some requests are illegal: any path not listed in R2 (for example DOZE to DEEP-SLEEP or RUN to DOZE), the code 7, and any request made while in SLEEP, DEEP-SLEEP, BACKUP or WAKE. An illegal request leaves the state unchanged and sets req_reject on the next edge. The next accepted request clears req_reject.
- R4: A RUN request made in SLOW keeps the state at SLOW and holds pll1_pd at 0 until pll1_lock is seen high. The state becomes RUN on the edge that samples pll1_lock=1.
- R5: The clock outputs depend on the state:
  - pll1_bypass is 0 only in RUN and STANDBY.
  - pll1_pd equals slow_pll_off in SLOW and DOZE (forced to 0 while waiting for lock), is 0 in RUN and STANDBY, and is 1 in all other states.
  - pll2_pd is 1 in SLEEP, DEEP-SLEEP, BACKUP and WAKE.
  - cpu_clk_sel selects 0=PLL in RUN and STANDBY, 1=crystal in SLOW, and in DOZE 3=32 kHz when doze_32k=1, otherwise 2=19 MHz. It is 3 in all other states.
  - cpu_clk_gate is 1 in STANDBY, SLEEP, DEEP-SLEEP, BACKUP and WAKE.
- R6: A vsel_wr strobe stores vsel_val as a pending code. core_vsel takes the pending code on the edge after a cycle spent in SLEEP, DEEP-SLEEP or BACKUP. In every other state core_vsel stays unchanged.
- R7: sdram_sr_req is 1 in the cycle after any cycle in which supply_ok or batt_ok is 0. It is also 1 throughout SLEEP and DEEP-SLEEP.
- R8: In SLEEP, wake_pin=1 or rtc_alarm=1 moves the state to SLOW on the next edge, and cpu_rst_n stays 1.
- R9: In DEEP-SLEEP and BACKUP, power_en, vdd_sw_en and cpu_rst_n are 0. A wake event moves the state to WAKE. In WAKE, power_en is 1, cpu_rst_n is 0, and vdd_sw_en is 0 until one 32 kHz tick has been counted in WAKE.
- R10: WAKE ends and the state becomes SLOW, with cpu_rst_n=1, on the edge that samples the DEEP_TICKS-th tick (default 8) after a deep-sleep wake. After a backup wake it is the BKUP_TICKS-th tick (default 66).
- R11: A wake event and a mode request in the same cycle in DEEP-SLEEP or BACKUP start the wake sequence, and req_reject goes to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 3 | Requested target state code |
| vsel_wr | input | 1 | Write strobe for the pending core voltage code |
| vsel_val | input | VSEL_W | Pending core voltage code |
| slow_pll_off | input | 1 | Power down PLL1 while in SLOW or DOZE |
| doze_32k | input | 1 | DOZE uses the 32 kHz clock instead of 19 MHz |
| pll1_lock | input | 1 | PLL1 lock flag |
| supply_ok | input | 1 | Supply-good flag |
| batt_ok | input | 1 | Battery-good flag |
| wake_pin | input | 1 | Wake pin level |
| rtc_alarm | input | 1 | RTC alarm pulse |
| tick32k | input | 1 | One-cycle 32 kHz tick |
| state_o | output | 3 | Current state code |
| req_reject | output | 1 | Last request was illegal |
| pll1_bypass | output | 1 | Bypass PLL1 |
| pll1_pd | output | 1 | Power down PLL1 |
| pll2_pd | output | 1 | Power down PLL2 |
| cpu_clk_sel | output | 2 | CPU clock source select |
| cpu_clk_gate | output | 1 | Gate the CPU clock |
| power_en | output | 1 | Main supply enable pin |
| vdd_sw_en | output | 1 | Core supply switch enable |
| cpu_rst_n | output | 1 | CPU reset, low holds the CPU in reset |
| sdram_sr_req | output | 1 | SDRAM self-refresh request |
| core_vsel | output | VSEL_W | Applied core voltage code |

## Verification
Two functions can fall in the same cycle: a wake event and a software mode request. In deep-sleep the bench raises wake_pin in the same cycle as a SLOW request. The cycle model expects the wake sequence to start and the request to be rejected. A supply fault is also raised while deep-sleep already requests self-refresh, and the request must stay high without a glitch. Every output is compared on every clock against a behavioural model. Directed checks count the 32 kHz ticks spent in WAKE.

// File: rtl/pwr_seq_pkg.sv
// Shared types and helpers for the power state sequencer.
// Assumes: 3-bit state code visible to software; codes fixed as listed.
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        PS_RUN   = 3'd0,
        PS_SLOW  = 3'd1,
        PS_DOZE  = 3'd2,
        PS_STBY  = 3'd3,
        PS_SLEEP = 3'd4,
        PS_DEEP  = 3'd5,
        PS_BKUP  = 3'd6,
        PS_WAKE  = 3'd7
    } pwr_state_e;

    localparam logic [1:0] CLK_PLL  = 2'd0;
    localparam logic [1:0] CLK_XTAL = 2'd1;
    localparam logic [1:0] CLK_19M  = 2'd2;
    localparam logic [1:0] CLK_32K  = 2'd3;

    // Permitted software path from a hardware-run state to a target code.
    function automatic logic req_legal(pwr_state_e cur, logic [2:0] tgt);
        logic ok;
        case (cur)
            PS_RUN:  ok = (tgt == PS_RUN) || (tgt == PS_SLOW) || (tgt == PS_STBY);
            PS_STBY: ok = (tgt == PS_RUN) || (tgt == PS_STBY);
            PS_SLOW: ok = (tgt != PS_STBY) && (tgt != PS_WAKE);
            PS_DOZE: ok = (tgt == PS_SLOW) || (tgt == PS_DOZE) || (tgt == PS_SLEEP);
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

    // States in which the core voltage code may be changed.
    function automatic logic volt_window(pwr_state_e s);
        return (s == PS_SLEEP) || (s == PS_DEEP) || (s == PS_BKUP);
    endfunction

endpackage

// File: rtl/pwr_wake_timer.sv
// Counts 32 kHz ticks while the sequencer is in WAKE.
// Assumes: in_wake is low for at least one cycle between wake sequences,
// which clears the count; long_sel picks the backup delay.
module pwr_wake_timer #(
    parameter int DEEP_TICKS = 8,
    parameter int BKUP_TICKS = 66
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_wake,
    input  logic tick,
    input  logic long_sel,
    output logic done,
    output logic settled
);
    localparam int MAX_TICKS = (BKUP_TICKS > DEEP_TICKS) ? BKUP_TICKS : DEEP_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W-1:0] DEEP_LAST = CNT_W'(DEEP_TICKS - 1);
    localparam logic [CNT_W-1:0] BKUP_LAST = CNT_W'(BKUP_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    // Tick counter: cleared outside WAKE, advanced on each tick inside it.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_wake) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Terminal count selection and completion flags.
    always_comb begin
        last    = long_sel ? BKUP_LAST : DEEP_LAST;
        done    = in_wake && tick && (cnt_q == last);
        settled = (cnt_q != '0);
    end

    // R9: the core switch may only follow a counted tick.
    assert_settle_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settled) |-> ($past(tick) && $past(in_wake)))
        else $error("settled rose without a tick in WAKE");

endmodule

// File: rtl/pwr_mode_fsm.sv
// Mode state machine: accepts legal software requests, handles PLL1 relock
// before RUN, and steers wake from sleep, deep-sleep and backup.
// Assumes: wake_evt and timer_done are synchronous single-cycle qualifiers.
module pwr_mode_fsm
    import pwr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [2:0] req_mode,
    input  logic       pll1_lock,
    input  logic       wake_evt,
    input  logic       timer_done,
    output pwr_state_e state_q,
    output logic       relock_q,
    output logic       from_bkup_q,
    output logic       reject_q
);
    pwr_state_e state_d;
    logic       relock_d;
    logic       from_bkup_d;
    logic       reject_d;
    logic       req_ok;

    // Next-state and flag computation.
    always_comb begin
        state_d     = state_q;
        relock_d    = relock_q;
        from_bkup_d = from_bkup_q;
        reject_d    = reject_q;
        req_ok      = req_legal(state_q, req_mode);
        case (state_q)
            PS_SLEEP: begin
                if (wake_evt)  state_d  = PS_SLOW;
                if (req_valid) reject_d = 1'b1;
            end
            PS_DEEP, PS_BKUP: begin
                if (wake_evt) begin
                    state_d     = PS_WAKE;
                    from_bkup_d = (state_q == PS_BKUP);
                end
                if (req_valid) reject_d = 1'b1;
            end
            PS_WAKE: begin
                if (timer_done) state_d  = PS_SLOW;
                if (req_valid)  reject_d = 1'b1;
            end
            default: begin
                if (req_valid) begin
                    reject_d = !req_ok;
                    if (req_ok) begin
                        if ((state_q == PS_SLOW) && (req_mode == 3'(PS_RUN))) begin
                            relock_d = 1'b1;
                        end else begin
                            state_d = pwr_state_e'(req_mode);
                        end
                    end
                end else if (relock_q && pll1_lock) begin
                    state_d = PS_RUN;
                end
            end
        endcase
        if (state_d != PS_SLOW) relock_d = 1'b0;
    end

    // State and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= PS_SLOW;
            relock_q    <= 1'b0;
            from_bkup_q <= 1'b0;
            reject_q    <= 1'b0;
        end else begin
            state_q     <= state_d;
            relock_q    <= relock_d;
            from_bkup_q <= from_bkup_d;
            reject_q    <= reject_d;
        end
    end

    // R2: deep-sleep and backup are entered only from SLOW.
    assert_lowpower_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (((state_q == PS_DEEP) || (state_q == PS_BKUP)) && (state_q != $past(state_q)))
        |-> ($past(state_q) == PS_SLOW))
        else $error("deep/backup entered from wrong state");

    // R4: RUN is reached from SLOW only with PLL1 locked.
    assert_run_needs_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == PS_RUN) && ($past(state_q) == PS_SLOW)) |-> $past(pll1_lock))
        else $error("RUN entered without lock");

    // R3: a rejection without a concurrent wake or timer exit keeps the state.
    assert_reject_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(reject_q) && !$past(wake_evt) && !$past(timer_done)) |-> $stable(state_q))
        else $error("state moved on a rejected request");

    // R10: WAKE ends only on the timer's completion.
    assert_wake_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state_q) == PS_WAKE) && (state_q != PS_WAKE)) |-> $past(timer_done))
        else $error("WAKE left early");

endmodule

// File: rtl/pwr_out_ctrl.sv
// Output decode: per-state clock, supply and reset controls, the gated
// core voltage latch and the emergency self-refresh flag.
// Assumes: state is the registered FSM state; relock only set in SLOW.
module pwr_out_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int               VSEL_W    = 2,
    parameter logic [VSEL_W-1:0] VSEL_INIT = VSEL_W'(1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pwr_state_e        state,
    input  logic              relock,
    input  logic              settled,
    input  logic              slow_pll_off,
    input  logic              doze_32k,
    input  logic              vsel_wr,
    input  logic [VSEL_W-1:0] vsel_val,
    input  logic              supply_ok,
    input  logic              batt_ok,
    output logic              pll1_bypass,
    output logic              pll1_pd,
    output logic              pll2_pd,
    output logic [1:0]        cpu_clk_sel,
    output logic              cpu_clk_gate,
    output logic              power_en,
    output logic              vdd_sw_en,
    output logic              cpu_rst_n,
    output logic              sdram_sr_req,
    output logic [VSEL_W-1:0] core_vsel
);
    logic              fault_q;
    logic [VSEL_W-1:0] vsel_pend_q;

    // Fault capture and voltage latch: pending code applied only in a window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q     <= 1'b0;
            vsel_pend_q <= VSEL_INIT;
            core_vsel   <= VSEL_INIT;
        end else begin
            fault_q <= !(supply_ok && batt_ok);
            if (vsel_wr) vsel_pend_q <= vsel_val;
            if (volt_window(state)) core_vsel <= vsel_pend_q;
        end
    end

    // Per-state decode of clock, supply and reset controls.
    always_comb begin
        pll1_bypass  = 1'b1;
        pll1_pd      = 1'b1;
        pll2_pd      = 1'b1;
        cpu_clk_sel  = CLK_32K;
        cpu_clk_gate = 1'b1;
        power_en     = 1'b1;
        vdd_sw_en    = 1'b1;
        cpu_rst_n    = 1'b1;
        case (state)
            PS_RUN, PS_STBY: begin
                pll1_bypass  = 1'b0;
                pll1_pd      = 1'b0;
                pll2_pd      = 1'b0;
                cpu_clk_sel  = CLK_PLL;
                cpu_clk_gate = (state == PS_STBY);
            end
            PS_SLOW: begin
                pll1_pd      = slow_pll_off && !relock;
                pll2_pd      = 1'b0;
                cpu_clk_sel  = CLK_XTAL;
                cpu_clk_gate = 1'b0;
            end
            PS_DOZE: begin
                pll1_pd      = slow_pll_off;
                pll2_pd      = 1'b0;
                cpu_clk_sel  = doze_32k ? CLK_32K : CLK_19M;
                cpu_clk_gate = 1'b0;
            end
            PS_SLEEP: begin
            end
            PS_DEEP, PS_BKUP: begin
                power_en  = 1'b0;
                vdd_sw_en = 1'b0;
                cpu_rst_n = 1'b0;
            end
            default: begin
                vdd_sw_en = settled;
                cpu_rst_n = 1'b0;
            end
        endcase
        sdram_sr_req = fault_q || (state == PS_SLEEP) || (state == PS_DEEP);
    end

    // R6: outside the voltage window the applied code does not move.
    assert_vsel_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!volt_window(state) && !volt_window($past(state))) |-> $stable(core_vsel))
        else $error("core_vsel changed outside window");

    // R7: a supply or battery fault forces self-refresh next cycle.
    assert_fault_sr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!(supply_ok && batt_ok)) |-> sdram_sr_req)
        else $error("fault did not force self-refresh");

    // R10: CPU reset is released only when leaving WAKE.
    assert_rst_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_n) |-> ($past(state) == PS_WAKE))
        else $error("reset released outside WAKE exit");

endmodule

// File: rtl/pwr_seq_ctrl.sv
// Power state sequencing controller top: mode FSM, wake timer, output decode.
// Assumes: all inputs synchronous to clk; tick32k is a one-cycle strobe.
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int               DEEP_TICKS = 8,
    parameter int               BKUP_TICKS = 66,
    parameter int               VSEL_W     = 2,
    parameter logic [VSEL_W-1:0] VSEL_INIT  = VSEL_W'(1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_mode,
    input  logic              vsel_wr,
    input  logic [VSEL_W-1:0] vsel_val,
    input  logic              slow_pll_off,
    input  logic              doze_32k,
    input  logic              pll1_lock,
    input  logic              supply_ok,
    input  logic              batt_ok,
    input  logic              wake_pin,
    input  logic              rtc_alarm,
    input  logic              tick32k,
    output logic [2:0]        state_o,
    output logic              req_reject,
    output logic              pll1_bypass,
    output logic              pll1_pd,
    output logic              pll2_pd,
    output logic [1:0]        cpu_clk_sel,
    output logic              cpu_clk_gate,
    output logic              power_en,
    output logic              vdd_sw_en,
    output logic              cpu_rst_n,
    output logic              sdram_sr_req,
    output logic [VSEL_W-1:0] core_vsel
);
    pwr_state_e state;
    logic       relock;
    logic       from_bkup;
    logic       timer_done;
    logic       settled;
    logic       wake_evt;

    // Either wake source qualifies a wake.
    assign wake_evt = wake_pin || rtc_alarm;
    assign state_o  = state;

    pwr_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_mode   (req_mode),
        .pll1_lock  (pll1_lock),
        .wake_evt   (wake_evt),
        .timer_done (timer_done),
        .state_q    (state),
        .relock_q   (relock),
        .from_bkup_q(from_bkup),
        .reject_q   (req_reject)
    );

    pwr_wake_timer #(
        .DEEP_TICKS(DEEP_TICKS),
        .BKUP_TICKS(BKUP_TICKS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_wake (state == PS_WAKE),
        .tick    (tick32k),
        .long_sel(from_bkup),
        .done    (timer_done),
        .settled (settled)
    );

    pwr_out_ctrl #(
        .VSEL_W   (VSEL_W),
        .VSEL_INIT(VSEL_INIT)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .relock      (relock),
        .settled     (settled),
        .slow_pll_off(slow_pll_off),
        .doze_32k    (doze_32k),
        .vsel_wr     (vsel_wr),
        .vsel_val    (vsel_val),
        .supply_ok   (supply_ok),
        .batt_ok     (batt_ok),
        .pll1_bypass (pll1_bypass),
        .pll1_pd     (pll1_pd),
        .pll2_pd     (pll2_pd),
        .cpu_clk_sel (cpu_clk_sel),
        .cpu_clk_gate(cpu_clk_gate),
        .power_en    (power_en),
        .vdd_sw_en   (vdd_sw_en),
        .cpu_rst_n   (cpu_rst_n),
        .sdram_sr_req(sdram_sr_req),
        .core_vsel   (core_vsel)
    );

endmodule

// File: tb/pwr_seq_ctrl_tb.sv
`timescale 1ns/100ps
// Bench: behavioural cycle model compared every clock, plus directed checks.
module pwr_seq_ctrl_tb;
    localparam int DP = 8;
    localparam int BK = 66;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_mode = 3'd0;
    logic vsel_wr = 1'b0;
    logic [1:0] vsel_val = 2'd0;
    logic slow_pll_off = 1'b0;
    logic doze_32k = 1'b0;
    logic pll1_lock = 1'b0;
    logic supply_ok = 1'b1;
    logic batt_ok = 1'b1;
    logic wake_pin = 1'b0;
    logic rtc_alarm = 1'b0;
    logic tick32k = 1'b0;
    logic [2:0] state_o;
    logic req_reject, pll1_bypass, pll1_pd, pll2_pd, cpu_clk_gate;
    logic power_en, vdd_sw_en, cpu_rst_n, sdram_sr_req;
    logic [1:0] cpu_clk_sel, core_vsel;

    int checks = 0;
    int failures = 0;
    int tick_div = 0;
    int cycles = 0;
    bit finished = 0;

    // Reference model state.
    int m_st, m_relock, m_bk, m_rej, m_pend, m_core, m_fq, m_cnt;

    always #2.5 clk = ~clk;

    pwr_seq_ctrl #(.DEEP_TICKS(DP), .BKUP_TICKS(BK)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .vsel_wr(vsel_wr), .vsel_val(vsel_val), .slow_pll_off(slow_pll_off),
        .doze_32k(doze_32k), .pll1_lock(pll1_lock), .supply_ok(supply_ok),
        .batt_ok(batt_ok), .wake_pin(wake_pin), .rtc_alarm(rtc_alarm),
        .tick32k(tick32k), .state_o(state_o), .req_reject(req_reject),
        .pll1_bypass(pll1_bypass), .pll1_pd(pll1_pd), .pll2_pd(pll2_pd),
        .cpu_clk_sel(cpu_clk_sel), .cpu_clk_gate(cpu_clk_gate),
        .power_en(power_en), .vdd_sw_en(vdd_sw_en), .cpu_rst_n(cpu_rst_n),
        .sdram_sr_req(sdram_sr_req), .core_vsel(core_vsel)
    );

    function automatic bit legal(int c, int t);
        case (c)
            0: return t == 0 || t == 1 || t == 3;
            3: return t == 0 || t == 3;
            1: return t != 3 && t != 7;
            2: return t == 1 || t == 2 || t == 4;
            default: return 0;
        endcase
    endfunction

    task automatic chk(int act, int exp, string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Model update from the requirements at every edge.
    always @(posedge clk) begin
        int n_st, n_rl, n_bk, n_rej, n_cnt, last;
        bit wake, done;
        if (!rst_n) begin
            m_st = 1; m_relock = 0; m_bk = 0; m_rej = 0;
            m_pend = 1; m_core = 1; m_fq = 0; m_cnt = 0;
        end else begin
            wake = wake_pin || rtc_alarm;
            last = m_bk ? BK : DP;
            done = (m_st == 7) && tick32k && (m_cnt == last - 1);
            n_st = m_st; n_rl = m_relock; n_bk = m_bk; n_rej = m_rej;
            if (m_st == 4) begin
                if (wake) n_st = 1;
                if (req_valid) n_rej = 1;
            end else if (m_st == 5 || m_st == 6) begin
                if (wake) begin n_st = 7; n_bk = (m_st == 6); end
                if (req_valid) n_rej = 1;
            end else if (m_st == 7) begin
                if (done) n_st = 1;
                if (req_valid) n_rej = 1;
            end else if (req_valid) begin
                n_rej = legal(m_st, req_mode) ? 0 : 1;
                if (legal(m_st, req_mode)) begin
                    if (m_st == 1 && req_mode == 0) n_rl = 1;
                    else n_st = req_mode;
                end
            end else if (m_relock != 0 && pll1_lock) begin
                n_st = 0;
            end
            if (n_st != 1) n_rl = 0;
            n_cnt = (m_st != 7) ? 0 : (tick32k ? m_cnt + 1 : m_cnt);
            if (m_st == 4 || m_st == 5 || m_st == 6) m_core = m_pend;
            if (vsel_wr) m_pend = vsel_val;
            m_fq = (supply_ok && batt_ok) ? 0 : 1;
            m_st = n_st; m_relock = n_rl; m_bk = n_bk; m_rej = n_rej; m_cnt = n_cnt;
        end
    end

    // Compare every output against the model shortly after each edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && !finished) begin
            int e_byp, e_p1, e_p2, e_sel, e_gate, e_pwr, e_vdd, e_rst;
            e_byp = !(m_st == 0 || m_st == 3);
            e_p2 = (m_st >= 4);
            e_gate = (m_st >= 3);
            case (m_st)
                0, 3: begin e_p1 = 0; e_sel = 0; end
                1: begin e_p1 = slow_pll_off && (m_relock == 0); e_sel = 1; end
                2: begin e_p1 = slow_pll_off; e_sel = doze_32k ? 3 : 2; end
                default: begin e_p1 = 1; e_sel = 3; end
            endcase
            e_pwr = !(m_st == 5 || m_st == 6);
            e_vdd = e_pwr && !(m_st == 7 && m_cnt == 0);
            e_rst = (m_st < 5);
            chk(state_o, m_st, "R2 state");
            chk(req_reject, m_rej, "R3 reject");
            chk(pll1_bypass, e_byp, "R5 pll1_bypass");
            chk(pll1_pd, e_p1, "R5 pll1_pd");
            chk(pll2_pd, e_p2, "R5 pll2_pd");
            chk(cpu_clk_sel, e_sel, "R5 cpu_clk_sel");
            chk(cpu_clk_gate, e_gate, "R5 cpu_clk_gate");
            chk(core_vsel, m_core, "R6 core_vsel");
            chk(sdram_sr_req, (m_fq != 0) || m_st == 4 || m_st == 5, "R7 sdram_sr_req");
            chk(power_en, e_pwr, "R9 power_en");
            chk(vdd_sw_en, e_vdd, "R9 vdd_sw_en");
            chk(cpu_rst_n, e_rst, "R9 cpu_rst_n");
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_div++;
            tick32k = (tick_div % 4 == 0);
        end
    endtask

    task automatic req(int mode);
        req_valid = 1'b1;
        req_mode = 3'(mode);
        step(1);
        req_valid = 1'b0;
    endtask

    task automatic wake_count(int exp, string tag);
        int n = 0;
        int guard = 0;
        while (state_o == 3'd7 && guard < 2000) begin
            if (tick32k) n++;
            step(1);
            guard++;
        end
        chk(n, exp, tag);
        chk(state_o, 1, "R10 state SLOW after WAKE");
        chk(cpu_rst_n, 1, "R10 reset released");
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        chk(state_o, 1, "R1 reset state");
        chk(pll1_bypass, 1, "R1 bypass");
        chk(cpu_rst_n, 1, "R1 cpu_rst_n");
        chk(sdram_sr_req, 0, "R1 sr_req");
        chk(req_reject, 0, "R1 reject");
        chk(core_vsel, 1, "R1 core_vsel");
        // R4: relock before RUN.
        slow_pll_off = 1'b1;
        step(2);
        chk(pll1_pd, 1, "R5 pll1 off in SLOW");
        req(0);
        chk(pll1_pd, 0, "R4 pll1_pd released");
        step(3);
        chk(state_o, 1, "R4 waits for lock");
        pll1_lock = 1'b1;
        step(1);
        chk(state_o, 0, "R4 RUN after lock");
        // R6: voltage write in RUN stays pending.
        vsel_wr = 1'b1; vsel_val = 2'd3; step(1); vsel_wr = 1'b0;
        step(2);
        chk(core_vsel, 1, "R6 frozen in RUN");
        req(3); step(2); req(0); step(1);
        req(2);
        chk(req_reject, 1, "R3 RUN to DOZE rejected");
        chk(state_o, 0, "R3 state kept");
        // R7: fault in RUN.
        supply_ok = 1'b0; step(1);
        chk(sdram_sr_req, 1, "R7 fault forces self-refresh");
        supply_ok = 1'b1; step(2);
        req(1);
        chk(req_reject, 0, "R3 cleared by legal request");
        req(2); doze_32k = 1'b1; step(2); doze_32k = 1'b0; step(2);
        req(5);
        chk(state_o, 2, "R3 DOZE to DEEP rejected");
        req(4); step(3);
        chk(core_vsel, 3, "R6 applied in SLEEP");
        vsel_wr = 1'b1; vsel_val = 2'd2; step(1); vsel_wr = 1'b0;
        step(2);
        // R8: alarm wakes sleep.
        rtc_alarm = 1'b1; step(1); rtc_alarm = 1'b0;
        chk(state_o, 1, "R8 SLEEP to SLOW");
        chk(cpu_rst_n, 1, "R8 no reset");
        chk(core_vsel, 2, "R6 second code applied");
        req(5); step(5);
        batt_ok = 1'b0; step(3); batt_ok = 1'b1; step(2);
        // R11: wake and request together.
        wake_pin = 1'b1; req_valid = 1'b1; req_mode = 3'd1;
        step(1);
        wake_pin = 1'b0; req_valid = 1'b0;
        chk(state_o, 7, "R11 wake taken");
        chk(req_reject, 1, "R11 request rejected");
        wake_count(DP, "R10 deep wake ticks");
        req(6); step(6);
        rtc_alarm = 1'b1; step(1); rtc_alarm = 1'b0;
        chk(state_o, 7, "R9 backup wake");
        wake_count(BK, "R10 backup wake ticks");
        step(4);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule